// File: doc/BRIEF.md
# Sound-CPU I/O Register Page

This block sits between a small audio CPU's byte-wide bus and the peripherals around it. It decodes a 16-byte register page at the top of the CPU's zero page (0x00F0 to 0x00FF by default) inside a 64 KB address space. It also lays a switchable boot-ROM image over the last 64 bytes of memory. Every CPU write also goes out unchanged on the RAM port, including writes that land in the register page or under the ROM. Reads outside the page and outside an active ROM window return the RAM's data.

Inside the page there are several kinds of register. A control byte holds the timer enables, the port-clear strobes and the ROM switch. An index byte selects one entry of a 128-entry DSP register file, and a data byte reaches that entry indirectly. Four host ports each have separate latches for each direction. There are two plain storage bytes and three write-only timer targets. Three counter bytes read the 4-bit timer counts and clear them on read. The CPU core, the DSP and the timers are outside this block and connect through the listed signals. Reads are combinational from the address, and register updates take effect on the next rising clock edge.

Top module: `snd_io_page`

## Requirements
- R1: While `rst` is high, and after it, the ROM overlay is on, all timer enables are 0, all port latches are 0, the DSP index is 0, the scratch bytes are 0 and all timer targets are 0.
- R2: Every CPU write at any address drives `ram_we` high in the same cycle, with `ram_addr` equal to `cpu_addr` and `ram_wdata` equal to `cpu_wdata`. This includes page registers and the ROM window. No RAM write happens without a CPU write.
- R3: A write to page offset 0x1 (control) sets `tmr_en[2:0]` to data bits 2..0 and the ROM overlay switch to data bit 7, from the next cycle on.
- R4: A control write with data bit 4 set clears the host-to-CPU latches of ports 0 and 1. Data bit 5 clears those of ports 2 and 3. When a host write hits a latch in the same cycle as its clear, the clear wins.
- R5: Offset 0x2 reads back the 8-bit DSP index as written. Offset 0x3 reads `dsp_rdata`, and `dsp_addr` always equals the low 7 bits of the index.
- R6: A write to offset 0x3 pulses `dsp_we`, with `dsp_wdata` equal to the written byte, only when index bit 7 is 0. When index bit 7 is 1 the write is dropped and `dsp_we` stays low.
- R7: Offsets 0x4 to 0x7 are ports 0 to 3. A CPU write goes to byte i of `port_out` (bits 8i+7..8i). A CPU read returns the latch last loaded through `host_wr[i]`/`host_wdata`.
- R8: Offsets 0x8 and 0x9 are two independent storage bytes that read back what was last written.
- R9: Offsets 0xA to 0xC write timer targets 0 to 2 into `tmr_target` byte i. Offsets 0x0, 0x1 and 0xA to 0xC read as 0x00.
- R10: A read of offset 0xD+i returns `{4'h0, tmr_count[4i+3:4i]}` and pulses `tmr_clr[i]` in that cycle. At most one clear bit is high, and none is high without a read of a counter offset.
- R11: While the overlay is on, reads of 0xFFC0 to 0xFFFF return byte (addr-0xFFC0) of the ROM image parameter. While it is off, they return RAM data. Writes there reach RAM in both cases.
- R12: Reads outside the page and outside an active ROM window return `ram_rdata`. Writes there change no page register and do not pulse `dsp_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe (read side effects only) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, combinational from ram_addr |
| dsp_addr | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| host_wr | input | 4 | Per-port host write strobes |
| host_wdata | input | 8 | Host write data |
| port_out | output | 32 | CPU-to-host latches, byte i is port i |
| tmr_en | output | 3 | Timer enables |
| tmr_target | output | 24 | Timer targets, byte i is timer i |
| tmr_count | input | 12 | Timer counts, nibble i is timer i |
| tmr_clr | output | 3 | Clear-on-read pulses per timer |

## Verification
The bench keeps the default page base of 0x00F0 and the 64-byte window. It overrides the ROM image with its own computed pattern, so ROM reads cannot match a RAM byte or the default image by chance. The bench RAM covers the zero page and the top page, which lets a single run write under the active overlay, switch the overlay off and read the same bytes back from RAM. Two settings of the timer counts and DSP indices on both sides of 0x7F exercise the clear-on-read decode and the dropped indirect write.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;

    localparam int ADDR_W        = 16;
    localparam int DATA_W        = 8;
    localparam int PORTS         = 4;
    localparam int TIMERS        = 3;
    localparam int SCRATCH       = 2;
    localparam int CNT_W         = 4;
    localparam int DSP_IDX_W     = 7;
    localparam int ROM_BYTES_DEF = 64;

    // page offsets; the layout is fixed by the CPU's software contract
    localparam logic [3:0] OFF_CTRL = 4'h1;
    localparam logic [3:0] OFF_DIDX = 4'h2;
    localparam logic [3:0] OFF_DDAT = 4'h3;
    localparam logic [3:0] OFF_PORT = 4'h4;
    localparam logic [3:0] OFF_SCR  = 4'h8;
    localparam logic [3:0] OFF_TGT  = 4'hA;
    localparam logic [3:0] OFF_CNT  = 4'hD;

    // control byte bit positions
    localparam int CTRL_CLR_LO = 4;
    localparam int CTRL_CLR_HI = 5;
    localparam int CTRL_ROM    = 7;

    typedef enum logic [3:0] {
        ACC_MEM,
        ACC_RSVD,
        ACC_CTRL,
        ACC_DIDX,
        ACC_DDAT,
        ACC_PORT,
        ACC_SCR,
        ACC_TGT,
        ACC_CNT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [1:0] sub;
    } acc_sel_t;

    typedef struct packed {
        logic              rom_on;
        logic [TIMERS-1:0] tmr_en;
    } ctrl_t;

    function automatic logic in_span(logic [3:0] off, logic [3:0] base, int n);
        return (int'(off) >= int'(base)) && (int'(off) < int'(base) + n);
    endfunction

    function automatic logic [8*ROM_BYTES_DEF-1:0] rom_fill();
        logic [8*ROM_BYTES_DEF-1:0] v;
        v = '0;
        for (int i = 0; i < ROM_BYTES_DEF; i++)
            v[8*i +: 8] = 8'(i * 29 + 90) ^ 8'(i >> 2);
        return v;
    endfunction

endpackage

// File: rtl/snd_io_decode.sv
module snd_io_decode
    import snd_io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h00F0
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_sel_t          sel
);

    logic [3:0] off;
    logic       in_page;

    assign off     = addr[3:0];
    assign in_page = (addr[ADDR_W-1:4] == PAGE_BASE[ADDR_W-1:4]);

    always_comb begin
        sel.kind = ACC_MEM;
        sel.sub  = '0;
        if (in_page) begin
            sel.kind = ACC_RSVD;
            if (off == OFF_CTRL) begin
                sel.kind = ACC_CTRL;
            end else if (off == OFF_DIDX) begin
                sel.kind = ACC_DIDX;
            end else if (off == OFF_DDAT) begin
                sel.kind = ACC_DDAT;
            end else if (in_span(off, OFF_PORT, PORTS)) begin
                sel.kind = ACC_PORT;
                sel.sub  = 2'(off - OFF_PORT);
            end else if (in_span(off, OFF_SCR, SCRATCH)) begin
                sel.kind = ACC_SCR;
                sel.sub  = 2'(off - OFF_SCR);
            end else if (in_span(off, OFF_TGT, TIMERS)) begin
                sel.kind = ACC_TGT;
                sel.sub  = 2'(off - OFF_TGT);
            end else if (in_span(off, OFF_CNT, TIMERS)) begin
                sel.kind = ACC_CNT;
                sel.sub  = 2'(off - OFF_CNT);
            end
        end
    end

endmodule

// File: rtl/snd_io_regs.sv
module snd_io_regs
    import snd_io_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  acc_sel_t                  sel,
    input  logic [DATA_W-1:0]         wdata,
    output ctrl_t                     ctrl,
    output logic [DATA_W-1:0]         didx,
    output logic [DATA_W*SCRATCH-1:0] scr,
    output logic [DATA_W*TIMERS-1:0]  tgt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.rom_on <= 1'b1;
            ctrl.tmr_en <= '0;
            didx        <= '0;
            scr         <= '0;
            tgt         <= '0;
        end else if (we) begin
            case (sel.kind)
                ACC_CTRL: begin
                    ctrl.rom_on <= wdata[CTRL_ROM];
                    ctrl.tmr_en <= wdata[TIMERS-1:0];
                end
                ACC_DIDX: didx <= wdata;
                ACC_SCR: begin
                    for (int s = 0; s < SCRATCH; s++)
                        if (sel.sub == 2'(s))
                            scr[DATA_W*s +: DATA_W] <= wdata;
                end
                ACC_TGT: begin
                    for (int t = 0; t < TIMERS; t++)
                        if (sel.sub == 2'(t))
                            tgt[DATA_W*t +: DATA_W] <= wdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/snd_io_ports.sv
module snd_io_ports
    import snd_io_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PORTS-1:0]        cpu_we,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic [PORTS-1:0]        host_we,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic                    clr_lo,
    input  logic                    clr_hi,
    output logic [DATA_W*PORTS-1:0] to_host,
    output logic [DATA_W*PORTS-1:0] from_host
);

    for (genvar i = 0; i < PORTS; i++) begin : g_port
        logic clr;
        assign clr = (i < PORTS / 2) ? clr_lo : clr_hi;

        always_ff @(posedge clk) begin
            if (rst) begin
                to_host[DATA_W*i +: DATA_W]   <= '0;
                from_host[DATA_W*i +: DATA_W] <= '0;
            end else begin
                if (cpu_we[i])
                    to_host[DATA_W*i +: DATA_W] <= cpu_wdata;
                // a clear from the CPU side beats a same-cycle host load
                if (clr)
                    from_host[DATA_W*i +: DATA_W] <= '0;
                else if (host_we[i])
                    from_host[DATA_W*i +: DATA_W] <= host_wdata;
            end
        end
    end

endmodule

// File: rtl/snd_io_rom.sv
module snd_io_rom
    import snd_io_pkg::*;
#(
    parameter int                       ROM_BYTES = ROM_BYTES_DEF,
    parameter logic [8*ROM_BYTES-1:0]   ROM_IMAGE = rom_fill()
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [DATA_W-1:0] data
);

    localparam int                IDX_W    = $clog2(ROM_BYTES);
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((2 ** ADDR_W) - ROM_BYTES);

    logic [IDX_W-1:0] idx;

    assign hit  = (addr >= ROM_BASE);
    assign idx  = addr[IDX_W-1:0];
    assign data = ROM_IMAGE[{idx, 3'b000} +: DATA_W];

endmodule

// File: rtl/snd_io_page.sv
module snd_io_page
    import snd_io_pkg::*;
#(
    parameter logic [ADDR_W-1:0]      PAGE_BASE = 16'h00F0,
    parameter int                     ROM_BYTES = ROM_BYTES_DEF,
    parameter logic [8*ROM_BYTES-1:0] ROM_IMAGE = rom_fill()
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic [ADDR_W-1:0]       ram_addr,
    output logic                    ram_we,
    output logic [DATA_W-1:0]       ram_wdata,
    input  logic [DATA_W-1:0]       ram_rdata,
    output logic [DSP_IDX_W-1:0]    dsp_addr,
    output logic                    dsp_we,
    output logic [DATA_W-1:0]       dsp_wdata,
    input  logic [DATA_W-1:0]       dsp_rdata,
    input  logic [PORTS-1:0]        host_wr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic [DATA_W*PORTS-1:0] port_out,
    output logic [TIMERS-1:0]       tmr_en,
    output logic [DATA_W*TIMERS-1:0] tmr_target,
    input  logic [CNT_W*TIMERS-1:0] tmr_count,
    output logic [TIMERS-1:0]       tmr_clr
);

    acc_sel_t                  sel;
    ctrl_t                     ctrl;
    logic [DATA_W-1:0]         didx;
    logic [DATA_W*SCRATCH-1:0] scr;
    logic [DATA_W*PORTS-1:0]   port_in;
    logic [PORTS-1:0]          port_we;
    logic                      clr_lo;
    logic                      clr_hi;
    logic                      rom_hit;
    logic [DATA_W-1:0]         rom_byte;
    logic                      ctrl_wr;

    snd_io_decode #(.PAGE_BASE(PAGE_BASE)) i_decode (
        .addr (cpu_addr),
        .sel  (sel)
    );

    snd_io_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cpu_wr),
        .sel   (sel),
        .wdata (cpu_wdata),
        .ctrl  (ctrl),
        .didx  (didx),
        .scr   (scr),
        .tgt   (tmr_target)
    );

    assign ctrl_wr = cpu_wr && (sel.kind == ACC_CTRL);
    assign clr_lo  = ctrl_wr && cpu_wdata[CTRL_CLR_LO];
    assign clr_hi  = ctrl_wr && cpu_wdata[CTRL_CLR_HI];

    for (genvar i = 0; i < PORTS; i++) begin : g_pwe
        assign port_we[i] = cpu_wr && (sel.kind == ACC_PORT) && (sel.sub == 2'(i));
    end

    snd_io_ports i_ports (
        .clk        (clk),
        .rst        (rst),
        .cpu_we     (port_we),
        .cpu_wdata  (cpu_wdata),
        .host_we    (host_wr),
        .host_wdata (host_wdata),
        .clr_lo     (clr_lo),
        .clr_hi     (clr_hi),
        .to_host    (port_out),
        .from_host  (port_in)
    );

    snd_io_rom #(.ROM_BYTES(ROM_BYTES), .ROM_IMAGE(ROM_IMAGE)) i_rom (
        .addr (cpu_addr),
        .hit  (rom_hit),
        .data (rom_byte)
    );

    // every CPU write is mirrored into RAM, overlay or not
    assign ram_addr  = cpu_addr;
    assign ram_we    = cpu_wr;
    assign ram_wdata = cpu_wdata;

    // indirect DSP window: 7-bit index, writes with bit 7 set are dropped
    assign dsp_addr  = didx[DSP_IDX_W-1:0];
    assign dsp_wdata = cpu_wdata;
    assign dsp_we    = cpu_wr && (sel.kind == ACC_DDAT) && !didx[DATA_W-1];

    assign tmr_en = ctrl.tmr_en;

    for (genvar t = 0; t < TIMERS; t++) begin : g_clr
        assign tmr_clr[t] = cpu_rd && (sel.kind == ACC_CNT) && (sel.sub == 2'(t));
    end

    always_comb begin
        cpu_rdata = '0;
        case (sel.kind)
            ACC_DIDX: cpu_rdata = didx;
            ACC_DDAT: cpu_rdata = dsp_rdata;
            ACC_PORT: begin
                for (int p = 0; p < PORTS; p++)
                    if (sel.sub == 2'(p))
                        cpu_rdata = port_in[DATA_W*p +: DATA_W];
            end
            ACC_SCR: begin
                for (int s = 0; s < SCRATCH; s++)
                    if (sel.sub == 2'(s))
                        cpu_rdata = scr[DATA_W*s +: DATA_W];
            end
            ACC_CNT: begin
                for (int t = 0; t < TIMERS; t++)
                    if (sel.sub == 2'(t))
                        cpu_rdata = {{(DATA_W-CNT_W){1'b0}}, tmr_count[CNT_W*t +: CNT_W]};
            end
            ACC_MEM: cpu_rdata = (rom_hit && ctrl.rom_on) ? rom_byte : ram_rdata;
            default: cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/snd_io_page_chk.sv
module snd_io_page_chk
    import snd_io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h00F0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic                     cpu_rd,
    input logic                     cpu_wr,
    input logic [DATA_W-1:0]        cpu_wdata,
    input logic [DATA_W-1:0]        cpu_rdata,
    input logic                     dsp_we,
    input logic [TIMERS-1:0]        tmr_en,
    input logic [TIMERS-1:0]        tmr_clr,
    input logic [DATA_W*PORTS-1:0]  port_out
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(PAGE_BASE + 16'd1);
    localparam logic [ADDR_W-1:0] A_DIDX = ADDR_W'(PAGE_BASE + 16'd2);
    localparam logic [ADDR_W-1:0] A_P0   = ADDR_W'(PAGE_BASE + 16'd4);

    // independent shadow of the index's top bit, taken from bus writes
    logic idx_hi_q;
    always_ff @(posedge clk) begin
        if (rst)
            idx_hi_q <= 1'b0;
        else if (cpu_wr && cpu_addr == A_DIDX)
            idx_hi_q <= cpu_wdata[DATA_W-1];
    end

    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tmr_en == '0 && port_out == '0));

    // R3
    ctrl_en_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == A_CTRL) |=> (tmr_en == $past(cpu_wdata[TIMERS-1:0])));

    // R6
    dsp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> !idx_hi_q);

    // R7
    port_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == A_P0) |=> (port_out[DATA_W-1:0] == $past(cpu_wdata)));

    // R9
    wo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == A_CTRL) |-> (cpu_rdata == '0));

    // R10
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_clr));

    // R10
    clr_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_clr != '0) |-> cpu_rd);

endmodule

bind snd_io_page snd_io_page_chk #(.PAGE_BASE(PAGE_BASE)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .dsp_we    (dsp_we),
    .tmr_en    (tmr_en),
    .tmr_clr   (tmr_clr),
    .port_out  (port_out)
);

// File: tb/test_snd_io_page.sv
module test_snd_io_page;
    timeunit 1ns;
    timeprecision 1ps;

    function automatic logic [8*64-1:0] tb_rom();
        logic [8*64-1:0] v;
        for (int i = 0; i < 64; i++) v[8*i +: 8] = 8'hC3 ^ 8'(i * 7);
        return v;
    endfunction
    localparam logic [8*64-1:0] TB_ROM = tb_rom();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [15:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [6:0]  dsp_addr;
    logic        dsp_we;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic [3:0]  host_wr = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] port_out;
    logic [2:0]  tmr_en;
    logic [23:0] tmr_target;
    logic [11:0] tmr_count = 12'hA5C;
    logic [2:0]  tmr_clr;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snd_io_page #(.ROM_IMAGE(TB_ROM)) i_snd_io_page (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .dsp_addr(dsp_addr), .dsp_we(dsp_we),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
        .port_out(port_out), .tmr_en(tmr_en), .tmr_target(tmr_target), .tmr_count(tmr_count),
        .tmr_clr(tmr_clr)
    );

    // environment: RAM covering zero page and top page, DSP register file
    logic [7:0] ram_lo [256];
    logic [7:0] ram_hi [256];
    logic [7:0] dsp_mem [128];
    initial begin
        for (int i = 0; i < 256; i++) begin
            ram_lo[i] = 8'(i) ^ 8'h5A;
            ram_hi[i] = 8'(i) ^ 8'hA5;
        end
        for (int i = 0; i < 128; i++) dsp_mem[i] = 8'(i + 3);
    end
    always_comb begin
        if (ram_addr[15:8] == 8'h00)      ram_rdata = ram_lo[ram_addr[7:0]];
        else if (ram_addr[15:8] == 8'hFF) ram_rdata = ram_hi[ram_addr[7:0]];
        else                              ram_rdata = 8'hEE;
    end
    assign dsp_rdata = dsp_mem[dsp_addr];
    always @(posedge clk) begin
        if (ram_we && ram_addr[15:8] == 8'h00) ram_lo[ram_addr[7:0]] <= ram_wdata;
        if (ram_we && ram_addr[15:8] == 8'hFF) ram_hi[ram_addr[7:0]] <= ram_wdata;
        if (dsp_we) dsp_mem[dsp_addr] <= dsp_wdata;
    end

    // behavioural reference state
    bit         m_rom = 1'b1;
    logic [2:0] m_en = '0;
    logic [7:0] m_idx = '0;
    logic [7:0] m_out [4] = '{default: 8'h00};
    logic [7:0] m_in  [4] = '{default: 8'h00};
    logic [7:0] m_scr [2] = '{default: 8'h00};
    logic [7:0] m_tgt [3] = '{default: 8'h00};

    function automatic logic [7:0] env_ram(logic [15:0] a);
        if (a[15:8] == 8'h00) return ram_lo[a[7:0]];
        if (a[15:8] == 8'hFF) return ram_hi[a[7:0]];
        return 8'hEE;
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        int o;
        o = int'(a[3:0]);
        if (a[15:4] == 12'h00F) begin
            if (o == 2) return m_idx;
            if (o == 3) return dsp_mem[m_idx[6:0]];
            if (o >= 4 && o <= 7) return m_in[o-4];
            if (o == 8 || o == 9) return m_scr[o-8];
            if (o >= 13) return {4'h0, tmr_count[4*(o-13) +: 4]};
            return 8'h00;
        end
        if (m_rom && a >= 16'hFFC0) return 8'hC3 ^ 8'(int'(a - 16'hFFC0) * 7);
        return env_ram(a);
    endfunction

    function automatic string req_of(logic [15:0] a);
        int o;
        o = int'(a[3:0]);
        if (a[15:4] == 12'h00F) begin
            if (o == 2 || o == 3) return "R5";
            if (o >= 4 && o <= 7) return "R4 R7";
            if (o == 8 || o == 9) return "R8";
            if (o >= 13) return "R10";
            return "R9";
        end
        if (a >= 16'hFFC0) return "R11";
        return "R12";
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %t: actual %h expected %h", rq, what, $time, act, exp);
        end
    endtask

    task automatic step(logic [15:0] a, logic rd, logic wr, logic [7:0] d,
                        logic [3:0] hw, logic [7:0] hd);
        logic [31:0] po;
        logic [23:0] tg;
        logic [2:0]  clr;
        bit          cl_lo, cl_hi;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        host_wr = hw; host_wdata = hd;
        #1;
        for (int i = 0; i < 4; i++) po[8*i +: 8] = m_out[i];
        for (int i = 0; i < 3; i++) tg[8*i +: 8] = m_tgt[i];
        for (int i = 0; i < 3; i++) clr[i] = rd && (a == 16'h00FD + 16'(i));
        chk(req_of(a), "cpu_rdata", 32'(cpu_rdata), 32'(exp_read(a)));
        chk("R2", "ram_we", 32'(ram_we), 32'(wr));
        if (wr) begin
            chk("R2", "ram_addr", 32'(ram_addr), 32'(a));
            chk("R2", "ram_wdata", 32'(ram_wdata), 32'(d));
        end
        chk("R6", "dsp_we", 32'(dsp_we), 32'(wr && a == 16'h00F3 && !m_idx[7]));
        chk("R5", "dsp_addr", 32'(dsp_addr), 32'(m_idx[6:0]));
        chk("R10", "tmr_clr", 32'(tmr_clr), 32'(clr));
        chk("R7", "port_out", port_out, po);
        chk("R3", "tmr_en", 32'(tmr_en), 32'(m_en));
        chk("R9", "tmr_target", 32'(tmr_target), 32'(tg));
        @(posedge clk);
        cl_lo = 1'b0; cl_hi = 1'b0;
        if (wr && a[15:4] == 12'h00F) begin
            case (a[3:0])
                4'h1: begin m_en = d[2:0]; m_rom = d[7]; cl_lo = d[4]; cl_hi = d[5]; end
                4'h2: m_idx = d;
                4'h4, 4'h5, 4'h6, 4'h7: m_out[int'(a[3:0]) - 4] = d;
                4'h8, 4'h9: m_scr[int'(a[3:0]) - 8] = d;
                4'hA, 4'hB, 4'hC: m_tgt[int'(a[3:0]) - 10] = d;
                default: ;
            endcase
        end
        for (int i = 0; i < 4; i++) begin
            if ((i < 2 && cl_lo) || (i >= 2 && cl_hi)) m_in[i] = 8'h00;
            else if (hw[i]) m_in[i] = hd;
        end
    endtask

    task automatic rd_(logic [15:0] a);
        step(a, 1'b1, 1'b0, 8'h00, 4'h0, 8'h00);
    endtask
    task automatic wr_(logic [15:0] a, logic [7:0] d);
        step(a, 1'b0, 1'b1, d, 4'h0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: state during reset
        #1;
        chk("R1", "port_out in reset", port_out, 32'h0);
        chk("R1", "tmr_en in reset", 32'(tmr_en), 32'h0);
        chk("R1", "tmr_target in reset", 32'(tmr_target), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // R1 / R11: overlay active after reset
        rd_(16'hFFC0);
        rd_(16'hFFFF);
        rd_(16'h00F2);
        rd_(16'h00F8);
        rd_(16'h00F1);
        // R12: plain RAM
        wr_(16'h0010, 8'h33);
        rd_(16'h0010);
        rd_(16'h1234);
        // R3: control
        wr_(16'h00F1, 8'h85);
        rd_(16'h00F0);
        // R11: writes under active overlay reach RAM
        wr_(16'hFFC5, 8'h77);
        rd_(16'hFFC5);
        rd_(16'hFFBF);
        wr_(16'h00F1, 8'h02);
        rd_(16'hFFC5);
        rd_(16'hFFC6);
        wr_(16'h00F1, 8'h80);
        rd_(16'hFFC5);
        // R5 / R6: DSP window
        wr_(16'h00F2, 8'h15);
        rd_(16'h00F2);
        wr_(16'h00F3, 8'h9C);
        rd_(16'h00F3);
        wr_(16'h00F2, 8'h95);
        rd_(16'h00F2);
        rd_(16'h00F3);
        wr_(16'h00F3, 8'h11);
        rd_(16'h00F3);
        wr_(16'h00F2, 8'h7F);
        wr_(16'h00F3, 8'h4E);
        rd_(16'h00F3);
        // R7: ports
        step(16'h0000, 1'b0, 1'b0, 8'h00, 4'b0110, 8'h42);
        step(16'h0000, 1'b0, 1'b0, 8'h00, 4'b1001, 8'h99);
        rd_(16'h00F4); rd_(16'h00F5); rd_(16'h00F6); rd_(16'h00F7);
        wr_(16'h00F4, 8'hAB);
        wr_(16'h00F7, 8'hCD);
        rd_(16'h00F4);
        // R4: clear low pair with a same-cycle host write
        step(16'h00F1, 1'b0, 1'b1, 8'h90, 4'b0101, 8'h55);
        rd_(16'h00F4); rd_(16'h00F5); rd_(16'h00F6); rd_(16'h00F7);
        step(16'h00F1, 1'b0, 1'b1, 8'hA0, 4'b0001, 8'h66);
        rd_(16'h00F4); rd_(16'h00F6); rd_(16'h00F7);
        // R8: scratch
        wr_(16'h00F8, 8'h3C);
        wr_(16'h00F9, 8'hC3);
        rd_(16'h00F8); rd_(16'h00F9);
        // R9: targets and write-only reads
        wr_(16'h00FA, 8'h10);
        wr_(16'h00FB, 8'h20);
        wr_(16'h00FC, 8'hFF);
        rd_(16'h00FA); rd_(16'h00FC);
        // R10: counters
        rd_(16'h00FD); rd_(16'h00FE); rd_(16'h00FF);
        wr_(16'h00FD, 8'h01);
        @(negedge clk) tmr_count = 12'h3F1;
        rd_(16'h00FF); rd_(16'h00FD);
        // R12: outside the page leaves registers and DSP untouched
        wr_(16'h01F3, 8'h21);
        wr_(16'h00E2, 8'h21);
        rd_(16'h00F2);
        rd_(16'h00E2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule